// File: doc/BRIEF.md
# Watchdog Timer Controller with Guarded Configuration

This block is a watchdog timer that is configured and observed through one 8-bit control/status register. A free-running counter measures the interval since the last kick. When that interval reaches the period chosen by a 4-bit select field, the block acts according to its operating mode. It can set an interrupt flag, issue a one-cycle system reset pulse, or set the flag first and then reset if the first warning is not serviced. The mode follows from the interrupt-enable and reset-enable bits, unless the lock fuse input forces reset behaviour.

The period select is guarded, and so is the act of clearing the reset enable. Software must first write the register with both the change-enable bit and the reset-enable bit set. This opens a short unlock window, and the window closes by itself after a fixed number of cycles. Any change to the guarded fields made outside the window is discarded. Each reset pulse sets a sticky watchdog-reset flag. While that flag stands, the reset enable is held at 1, so a failing system keeps resetting until software explicitly clears the flag.

The processor supplies a global interrupt enable and an interrupt acknowledge. The oscillator, the fuse storage and the processor itself lie outside the block.

Top module: `wdt_guard`

## Requirements
- R1: After reset, every register bit reads 0, and `irq_o`, `sysrst_o` and `rflag_o` are 0.
- R2: `rdata_o` shows the register as follows: bit 7 interrupt flag, bit 6 interrupt enable, bit 5 select bit 3, bit 4 change enable, bit 3 reset enable, bits 2..0 select bits 2..0. A write always updates the interrupt enable. Writing 1 to bit 7 clears the flag, and writing 0 to bit 7 leaves it unchanged.
- R3: With the fuse low and both enables 0, the block is stopped. The counter does not advance and no time-out occurs.
- R4: In interrupt mode (interrupt enable 1, reset enable 0), a time-out sets the flag. `irq_o` equals flag AND interrupt enable AND `gie_i`.
- R5: `ack_i` clears the flag. When it arrives in interrupt-then-reset mode, it also clears the interrupt enable, which leaves the block in reset mode.
- R6: In interrupt-then-reset mode (both enables 1), a time-out sets the flag if the flag is 0. If the flag is already 1, the time-out issues a reset pulse instead.
- R7: In reset mode (reset enable 1, interrupt enable 0, or `fuse_i` high whatever the register holds), a time-out drives `sysrst_o` high for exactly one cycle and sets `rflag_o` on the same edge.
- R8: While running, a time-out occurs 2^(BASE_LOG2+s) cycles after the counter was last zeroed, where s is the select value. A select above NUM_SEL-1 behaves as NUM_SEL-1. The counter is zeroed by a kick, by a time-out, and while stopped.
- R9: `kick_i` zeroes the counter, and a kick on the edge where a time-out would fall suppresses that time-out.
- R10: A write with bits 4 and 3 both 1 opens the unlock window. Bit 4 then reads 1 for exactly WIN_CYC cycles. A write during the window loads the select and the reset enable from the data and closes the window.
- R11: Outside the window, a write leaves the select unchanged and cannot clear the reset enable. Setting the reset enable is always accepted.
- R12: While `rflag_o` is 1, the reset enable reads 1 and cannot be cleared. `rflag_o` stays 1 until `rflag_clr_i`, and after that the reset enable remains 1 until it is cleared through the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read value |
| kick_i | input | 1 | Zero the watchdog counter |
| gie_i | input | 1 | Global interrupt enable from the processor |
| ack_i | input | 1 | Interrupt acknowledge |
| fuse_i | input | 1 | Lock fuse, forces reset mode when 1 |
| rflag_clr_i | input | 1 | Clear the watchdog-reset flag |
| rflag_o | output | 1 | Sticky watchdog-reset flag |
| irq_o | output | 1 | Interrupt request |
| sysrst_o | output | 1 | One-cycle system reset pulse |

## Verification
The bench builds the block with BASE_LOG2 = 3, NUM_SEL = 10 and WIN_CYC = 4. Periods therefore run from 8 to 4096 cycles, instead of 2048 to about a million. At that scale, repeated time-outs in every mode, the two-stage warn-then-reset sequence and the reserved select values that clamp to the longest period all fit in a short run. The four-cycle unlock window is exercised at its last accepted cycle and its first rejected cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_IRQ     = 2'd1,
    MODE_RST     = 2'd2,
    MODE_IRQ_RST = 2'd3
  } wdt_mode_e;

  localparam int B_FLAG = 7;
  localparam int B_IEN  = 6;
  localparam int B_PS3  = 5;
  localparam int B_UNLK = 4;
  localparam int B_REN  = 3;

  typedef struct packed {
    logic       flag;
    logic       ien;
    logic       unlk;
    logic       ren;
    logic [3:0] ps;
  } wdt_ctl_t;

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int BASE_LOG2 = 11,
  parameter int NUM_SEL   = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       kick_i,
  input  logic [3:0] sel_i,
  output logic       timeout_o
);
  localparam int         CNT_W   = BASE_LOG2 + NUM_SEL - 1;
  localparam logic [3:0] SEL_MAX = 4'(NUM_SEL - 1);

  logic [3:0]       sel_c;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;

  // reserved select codes fall back to the longest period
  assign sel_c = (sel_i > SEL_MAX) ? SEL_MAX : sel_i;

  // terminal count 2^(BASE_LOG2+sel)-1 as a thermometer of ones
  for (genvar k = 0; k < CNT_W; k++) begin : g_lim
    if (k < BASE_LOG2) begin : g_low
      assign limit[k] = 1'b1;
    end else begin : g_high
      assign limit[k] = (int'(sel_c) > (k - BASE_LOG2));
    end
  end

  // >= keeps a shortened period from being skipped over
  assign timeout_o = run_i & ~kick_i & (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || kick_i || timeout_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/wdt_ctl_regs.sv
module wdt_ctl_regs
  import wdt_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       ack_i,
  input  logic       set_flag_i,
  input  logic       rflag_i,
  input  logic       fuse_i,
  output wdt_ctl_t   ctl_o
);
  localparam int WIN_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;

  logic             flag_q, ien_q, unlk_q, ren_q;
  logic [3:0]       ps_q;
  logic [WIN_W-1:0] win_q;
  logic             ren_eff, open_req, two_stage, flag_w1c;

  assign ren_eff   = ren_q | rflag_i;
  assign open_req  = we_i & wdata_i[B_UNLK] & wdata_i[B_REN] & ~unlk_q;
  assign two_stage = ~fuse_i & ren_eff & ien_q;
  assign flag_w1c  = we_i & wdata_i[B_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      unlk_q <= 1'b0;
      ren_q  <= 1'b0;
      ps_q   <= '0;
      win_q  <= '0;
    end else begin
      if (we_i && unlk_q) begin
        // guarded write inside the window, consumes it
        unlk_q <= 1'b0;
        ps_q   <= {wdata_i[B_PS3], wdata_i[2:0]};
        ren_q  <= wdata_i[B_REN] | rflag_i;
      end else begin
        ren_q <= ren_q | rflag_i | (we_i & wdata_i[B_REN]);
        if (open_req) begin
          unlk_q <= 1'b1;
          win_q  <= WIN_W'(WIN_CYC - 1);
        end else if (unlk_q) begin
          if (win_q == '0) unlk_q <= 1'b0;
          else             win_q  <= win_q - WIN_W'(1);
        end
      end
      ien_q  <= (we_i ? wdata_i[B_IEN] : ien_q) & ~(ack_i & two_stage);
      flag_q <= set_flag_i | (flag_q & ~ack_i & ~flag_w1c);
    end
  end

  assign ctl_o = '{flag: flag_q, ien: ien_q, unlk: unlk_q, ren: ren_eff, ps: ps_q};

endmodule

// File: rtl/wdt_mode_dec.sv
module wdt_mode_dec
  import wdt_pkg::*;
(
  input  logic fuse_i,
  input  logic ren_i,
  input  logic ien_i,
  input  logic flag_i,
  input  logic timeout_i,
  output logic run_o,
  output logic set_flag_o,
  output logic fire_o
);
  wdt_mode_e mode;

  always_comb begin
    mode       = fuse_i ? MODE_RST : wdt_mode_e'({ren_i, ien_i});
    set_flag_o = 1'b0;
    fire_o     = 1'b0;
    if (timeout_i) begin
      case (mode)
        MODE_IRQ:     set_flag_o = 1'b1;
        MODE_RST:     fire_o     = 1'b1;
        MODE_IRQ_RST: begin
          if (flag_i) fire_o     = 1'b1;
          else        set_flag_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign run_o = (mode != MODE_OFF);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int NUM_SEL   = 10,
  parameter int WIN_CYC   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       kick_i,
  input  logic       gie_i,
  input  logic       ack_i,
  input  logic       fuse_i,
  input  logic       rflag_clr_i,
  output logic       rflag_o,
  output logic       irq_o,
  output logic       sysrst_o
);
  wdt_ctl_t ctl;
  logic     run, timeout, set_flag, fire;
  logic     rflag_q, sysrst_q;

  wdt_ctl_regs #(.WIN_CYC(WIN_CYC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .ack_i      (ack_i),
    .set_flag_i (set_flag),
    .rflag_i    (rflag_q),
    .fuse_i     (fuse_i),
    .ctl_o      (ctl)
  );

  wdt_mode_dec u_mode (
    .fuse_i     (fuse_i),
    .ren_i      (ctl.ren),
    .ien_i      (ctl.ien),
    .flag_i     (ctl.flag),
    .timeout_i  (timeout),
    .run_o      (run),
    .set_flag_o (set_flag),
    .fire_o     (fire)
  );

  wdt_counter #(.BASE_LOG2(BASE_LOG2), .NUM_SEL(NUM_SEL)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .kick_i    (kick_i),
    .sel_i     (ctl.ps),
    .timeout_o (timeout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rflag_q  <= 1'b0;
      sysrst_q <= 1'b0;
    end else begin
      rflag_q  <= fire | (rflag_q & ~rflag_clr_i);
      sysrst_q <= fire;
    end
  end

  assign rdata_o  = {ctl.flag, ctl.ien, ctl.ps[3], ctl.unlk, ctl.ren, ctl.ps[2:0]};
  assign irq_o    = ctl.flag & ctl.ien & gie_i;
  assign rflag_o  = rflag_q;
  assign sysrst_o = sysrst_q;

endmodule

// File: rtl/wdt_guard_sva.sv
module wdt_guard_sva #(
  parameter int WIN_CYC = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] rdata_o,
  input logic       gie_i,
  input logic       rflag_clr_i,
  input logic       rflag_o,
  input logic       irq_o,
  input logic       sysrst_o
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hi_cnt <= '0;
    else if (!rdata_o[4])               hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF)        hi_cnt <= hi_cnt + 16'd1;
  end

  p_irq_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_i && rdata_o[6] && rdata_o[7]));

  p_rst_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysrst_o |=> !sysrst_o);

  p_rst_marks_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysrst_o |-> rflag_o);

  p_window_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[4] |-> (hi_cnt < 16'(WIN_CYC)));

  p_sel_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[4] |=> $stable({rdata_o[5], rdata_o[2:0]}));

  p_ren_forced_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rflag_o |-> rdata_o[3]);

  p_rflag_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rflag_o && !rflag_clr_i) |=> rflag_o);

endmodule

bind wdt_guard wdt_guard_sva #(.WIN_CYC(WIN_CYC)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rdata_o     (rdata_o),
  .gie_i       (gie_i),
  .rflag_clr_i (rflag_clr_i),
  .rflag_o     (rflag_o),
  .irq_o       (irq_o),
  .sysrst_o    (sysrst_o)
);

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
  localparam int BASE = 3;
  localparam int NSEL = 10;
  localparam int WIN  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, kick = 1'b0, gie = 1'b0, ack = 1'b0, fuse = 1'b0, rclr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rflag, irq, sysrst;

  int    n_chk = 0, n_err = 0;
  bit    done = 1'b0;
  string phase = "R1 reset";

  always #10 clk = ~clk;

  wdt_guard #(.BASE_LOG2(BASE), .NUM_SEL(NSEL), .WIN_CYC(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .kick_i(kick), .gie_i(gie), .ack_i(ack), .fuse_i(fuse),
    .rflag_clr_i(rclr), .rflag_o(rflag), .irq_o(irq), .sysrst_o(sysrst)
  );

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_flag, m_ien, m_unlk, m_ren, m_rflag, m_sys;
  int m_ps, m_win, m_cnt;
  bit ren_e, to, fire, setf, two, n_ien, n_flag, n_ren, n_rflag;
  int md;

  function automatic int lim_of(int s);
    int e = (s > NSEL - 1) ? NSEL - 1 : s;
    return (1 << (BASE + e)) - 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; m_ien = 0; m_unlk = 0; m_ren = 0; m_rflag = 0; m_sys = 0;
      m_ps = 0; m_win = 0; m_cnt = 0;
    end else begin
      ren_e = m_ren | m_rflag;
      md    = fuse ? 2 : ((ren_e ? 2 : 0) + (m_ien ? 1 : 0));
      to    = (md != 0) && !kick && (m_cnt >= lim_of(m_ps));
      fire  = to && (md == 2 || (md == 3 && m_flag));
      setf  = to && (md == 1 || (md == 3 && !m_flag));
      m_cnt = (md == 0 || kick || to) ? 0 : m_cnt + 1;
      two   = !fuse && ren_e && m_ien;
      n_ien = we ? wdata[6] : m_ien;
      if (ack && two) n_ien = 0;
      n_flag = setf || (m_flag && !ack && !(we && wdata[7]));
      if (we && m_unlk) begin
        m_ps   = {wdata[5], wdata[2:0]};
        n_ren  = wdata[3] | m_rflag;
        m_unlk = 0;
      end else begin
        n_ren = m_ren | m_rflag | (we && wdata[3]);
        if (we && wdata[4] && wdata[3]) begin
          m_unlk = 1; m_win = WIN;
        end else if (m_unlk) begin
          m_win--;
          if (m_win == 0) m_unlk = 0;
        end
      end
      n_rflag = fire || (m_rflag && !rclr);
      m_ien = n_ien; m_flag = n_flag; m_ren = n_ren; m_rflag = n_rflag; m_sys = fire;
    end
  end

  function automatic int exp_rdata();
    return {m_flag, m_ien, 1'(m_ps >> 3), m_unlk, m_ren | m_rflag, 3'(m_ps)};
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk({phase, " / R2 rdata"},  rdata,  exp_rdata());
      chk({phase, " / R4 irq"},    irq,    m_flag & m_ien & gie);
      chk({phase, " / R7 sysrst"}, sysrst, m_sys);
      chk({phase, " / R12 rflag"}, rflag,  m_rflag);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [7:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_rclr();
    rclr = 1'b1; @(negedge clk); rclr = 1'b0;
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired in phase %s", phase);
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", rdata, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 sysrst after reset", sysrst, 0);
    chk("R1 rflag after reset", rflag, 0);

    phase = "R10 window";
    wr(8'h18); wr(8'h27);
    chk("R10 select loaded in window", rdata, 8'h27);
    wr(8'h18);
    chk("R10 change bit open", rdata[4], 1);
    idle(3);
    chk("R10 change bit fourth cycle", rdata[4], 1);
    idle(1);
    chk("R10 change bit expired", rdata[4], 0);

    phase = "R11 guarded";
    wr(8'h01);
    chk("R11 write outside window ignored", rdata, 8'h2F);

    phase = "R10 window last cycle";
    wr(8'h18); idle(3); wr(8'h01);
    chk("R10 write on last window cycle", rdata, 8'h01);

    phase = "R11 window expired";
    wr(8'h18); idle(4); wr(8'h02);
    chk("R11 write after expiry ignored", rdata, 8'h09);
    wr(8'h18); wr(8'h00);
    chk("R10 reset enable cleared in window", rdata, 8'h00);

    phase = "R4 irq mode";
    gie = 1'b1;
    wr(8'h40);
    chk("R2 interrupt enable field", rdata, 8'h40);
    idle(7);
    chk("R8 no time-out before period", rdata[7], 0);
    idle(1);
    chk("R8 time-out at period", rdata[7], 1);
    chk("R4 irq raised", irq, 1);
    gie = 1'b0; #1;
    chk("R4 irq masked by gie", irq, 0);

    phase = "R5 ack";
    pulse_ack();
    chk("R5 ack clears flag keeps enable", rdata, 8'h40);
    gie = 1'b1;

    phase = "R2 flag write-one-clear";
    idle(20); wr(8'hC0); idle(3); wr(8'h40); idle(9); wr(8'h40); idle(5);
    wr(8'h80);

    phase = "R9 kick";
    wr(8'h40);
    for (int i = 0; i < 10; i++) begin
      kick = 1'b1; @(negedge clk); kick = 1'b0;
      idle(4);
    end
    chk("R9 kicks prevent time-out", rdata[7], 0);
    wr(8'h80);

    phase = "R8 reserved select";
    wr(8'h18); wr(8'h27); wr(8'h40);
    idle(4095);
    chk("R8 reserved select not yet expired", rdata[7], 0);
    idle(1);
    chk("R8 reserved select uses longest period", rdata[7], 1);
    wr(8'h80); wr(8'h18); wr(8'h00);

    phase = "R6 two-stage";
    wr(8'h48);
    idle(8);
    chk("R6 first time-out sets flag", rdata[7], 1);
    chk("R6 first time-out no reset", sysrst, 0);
    idle(8);
    chk("R6 second time-out resets", sysrst, 1);
    chk("R7 reset sets rflag", rflag, 1);
    idle(1);
    chk("R7 reset pulse one cycle", sysrst, 0);
    idle(30);

    phase = "R5 ack two-stage";
    kick = 1'b1;
    pulse_ack();
    chk("R5 ack clears flag and enable", rdata[7:6], 0);

    phase = "R12 forced enable";
    wr(8'h18); wr(8'h00);
    chk("R12 reset enable held by rflag", rdata[3], 1);
    pulse_rclr();
    chk("R12 rflag cleared", rflag, 0);
    chk("R12 enable kept after flag clear", rdata[3], 1);
    wr(8'h18); wr(8'h00);
    chk("R12 enable clears once flag gone", rdata, 8'h00);
    kick = 1'b0;

    phase = "R3 stopped";
    idle(100);
    chk("R3 stopped no flag", rdata, 8'h00);
    chk("R3 stopped no reset", rflag, 0);

    phase = "R7 fuse";
    fuse = 1'b1;
    idle(8);
    chk("R7 fuse forces reset pulse", sysrst, 1);
    chk("R7 fuse reset sets rflag", rflag, 1);
    idle(20);
    fuse = 1'b0; kick = 1'b1;
    pulse_rclr();
    wr(8'h18); wr(8'h00);
    kick = 1'b0;
    idle(5);

    wrap_up();
  end

endmodule